// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Grouped Interrupts

This block controls a bank of general-purpose pins through a small register port. Each pin owns one 32-bit configuration word. That word holds the level to drive, a 3-bit mode, a bit that hands the pin to a peripheral, a configuration-done flag, and a 3-bit field that picks the interrupt group. A single mode field carries both the direction and the trigger type: output, input with no interrupt, level-high, level-low, rising edge, falling edge, or either edge.

Interrupt-capable inputs set a pending bit when their trigger condition occurs. Each pin reports to one of up to eight groups. A group shows its pins' pending bits in banked words of 32 pins each, and software clears them by writing ones to the bits it wants cleared. Each group drives one interrupt line, which stays high while any pin in that group is pending. Pin inputs arrive already synchronized. Pad control lies outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is in mode 7 with its level, peripheral, done and group fields at zero. All pending bits are clear, and pinOe, pinPeriph and irqOut are all low, so reading a configuration word returns 0x0000000E ORed with the pin's input level.
- R2: The configuration word of pin n sits at byte address 4*n. Its fields are: bit 0 level, bits 3:1 mode, bit 5 peripheral select, bit 9 done flag, bits 18:16 group. A read returns the stored fields, zero in every other bit, and the current pinIn level in bit 0. A write sets pinOut[n] from bit 0.
- R3: pinOe[n] is high only when the mode is 1 (output) and bit 5 is clear. pinPeriph[n] follows bit 5.
- R4: Mode 4 sets the pending bit on a 0-to-1 input change, mode 5 on a 1-to-0 change, and mode 6 on either change. The bit is set at the clock edge after the change. A steady level in these modes sets nothing more.
- R5: Mode 2 sets the pending bit on every cycle the input is high, and mode 3 on every cycle it is low. Clearing the bit while the level is still active leaves it set.
- R6: A pin in mode 0, 1 or 7, or with bit 5 set, never sets its pending bit.
- R7: The pending word for group g and pin p is at byte address 0x800 + 0x40*g + 4*(p>>5). Bit p mod 32 of that word shows pin p's pending flag, but only if p's group field equals g. Otherwise that bit reads zero.
- R8: Writing a pending word clears each pin of that group and word whose data bit is 1. Bits written as 0, and pins that belong to another group, are left unchanged.
- R9: irqOut[g] is high while any pin whose group field is g has its pending bit set.
- R10: Read data appears on busRdata in the cycle after the request. Addresses outside the configuration words and the existing pending words read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| pinOut | output | NUM_PINS | Level driven in output mode |
| pinOe | output | NUM_PINS | Output enable |
| pinPeriph | output | NUM_PINS | Pin handed to peripheral function |
| irqOut | output | NUM_GROUPS | One interrupt line per group |

## Verification
The hardest case to reach is a clear that must be selective: a pending word holds flags from two pins of the same group, while a pin of another group shares the same bit position. The bench builds that case. It arms three pins with rising-edge triggers across two groups and two words, and raises all three inputs in one cycle. It then writes ones into the wrong group's word, writes zeros into the right one, and clears one bit at a time. After each step it checks both the pending words and the group lines. Level modes are driven the other way: the input is held active while the clear is written, which shows that the flag comes back.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W  = 12;
  localparam int IDX_W   = 9;
  localparam int GRP_W   = 3;
  localparam int WORD_W  = 4;

  // mode codes held in bits 3:1 of a configuration word
  localparam logic [2:0] MD_OFF0    = 3'd0;
  localparam logic [2:0] MD_OUT     = 3'd1;
  localparam logic [2:0] MD_LVL_HI  = 3'd2;
  localparam logic [2:0] MD_LVL_LO  = 3'd3;
  localparam logic [2:0] MD_RISE    = 3'd4;
  localparam logic [2:0] MD_FALL    = 3'd5;
  localparam logic [2:0] MD_BOTH    = 3'd6;
  localparam logic [2:0] MD_IN_QUIET = 3'd7;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic              cfgWr;
    logic              cfgRd;
    logic              pendWr;
    logic              pendRd;
    logic [IDX_W-1:0]  pinIdx;
    logic [GRP_W-1:0]  grpIdx;
    logic [WORD_W-1:0] wordIdx;
  } ctrl_strobe_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrl_strobe_t      strb
);

  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam logic [ADDR_W:0] CFG_LIMIT = (ADDR_W+1)'(4 * NUM_PINS);
  localparam logic [GRP_W:0]  GRP_LIMIT = (GRP_W+1)'(NUM_GROUPS);
  localparam logic [WORD_W:0] WORD_LIMIT = (WORD_W+1)'(NUM_WORDS);

  logic inCfg;
  logic inPend;
  logic [1:0] unusedLow;

  assign unusedLow = busAddr[1:0];

  always_comb begin
    inCfg  = ({1'b0, busAddr} < CFG_LIMIT);
    inPend = busAddr[11] && (busAddr[10:9] == 2'b00)
             && ({1'b0, busAddr[8:6]} < GRP_LIMIT)
             && ({1'b0, busAddr[5:2]} < WORD_LIMIT);
  end

  always_comb begin
    strb         = '0;
    strb.pinIdx  = busAddr[10:2];
    strb.grpIdx  = busAddr[8:6];
    strb.wordIdx = busAddr[5:2];
    if (busValid) begin
      strb.cfgWr  = inCfg && busWrite;
      strb.cfgRd  = inCfg && !busWrite;
      strb.pendWr = inPend && busWrite;
      strb.pendRd = inPend && !busWrite;
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strb,
  input  logic [31:0]           wdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [31:0]           rdata,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_PINS-1:0]   pinPeriph,
  output logic [NUM_GROUPS-1:0] irqOut
);

  logic [NUM_PINS-1:0][2:0] modeQ;
  logic [NUM_PINS-1:0][2:0] grpQ;
  logic [NUM_PINS-1:0]      dataQ;
  logic [NUM_PINS-1:0]      periphQ;
  logic [NUM_PINS-1:0]      doneQ;
  logic [NUM_PINS-1:0]      pendQ;
  logic [NUM_PINS-1:0]      prevQ;
  logic [NUM_PINS-1:0]      trig;
  logic [NUM_PINS-1:0]      clrHit;
  logic [31:0]              rdNext;

  // trigger detection per pin
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      unique case (modeQ[p])
        MD_LVL_HI: trig[p] = pinIn[p];
        MD_LVL_LO: trig[p] = !pinIn[p];
        MD_RISE:   trig[p] = pinIn[p] && !prevQ[p];
        MD_FALL:   trig[p] = !pinIn[p] && prevQ[p];
        MD_BOTH:   trig[p] = pinIn[p] ^ prevQ[p];
        default:   trig[p] = 1'b0;
      endcase
      if (periphQ[p]) trig[p] = 1'b0;
    end
  end

  // write-one-to-clear selection
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      clrHit[p] = strb.pendWr && (grpQ[p] == strb.grpIdx)
                  && (strb.wordIdx == WORD_W'(p >> 5)) && wdata[p % 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        modeQ[p] <= MD_IN_QUIET;
        grpQ[p]  <= '0;
      end
      dataQ   <= '0;
      periphQ <= '0;
      doneQ   <= '0;
      pendQ   <= '0;
      prevQ   <= '0;
    end else begin
      prevQ <= pinIn;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (strb.cfgWr && (strb.pinIdx == IDX_W'(p))) begin
          dataQ[p]   <= wdata[0];
          modeQ[p]   <= wdata[3:1];
          periphQ[p] <= wdata[5];
          doneQ[p]   <= wdata[9];
          grpQ[p]    <= wdata[18:16];
        end
        if (trig[p])        pendQ[p] <= 1'b1;
        else if (clrHit[p]) pendQ[p] <= 1'b0;
      end
    end
  end

  // group lines
  always_comb begin
    irqOut = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pendQ[p] && (grpQ[p] == GRP_W'(g))) irqOut[g] = 1'b1;
      end
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    if (strb.cfgRd) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (strb.pinIdx == IDX_W'(p)) begin
          rdNext = {13'b0, grpQ[p], 6'b0, doneQ[p], 3'b0, periphQ[p], 1'b0,
                    modeQ[p], pinIn[p]};
        end
      end
    end else if (strb.pendRd) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if ((strb.wordIdx == WORD_W'(p >> 5)) && (grpQ[p] == strb.grpIdx))
          rdNext[p % 32] = pendQ[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pinOe[p] = (modeQ[p] == MD_OUT) && !periphQ[p];
    end
  end

  assign pinOut    = dataQ;
  assign pinPeriph = periphQ;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [11:0]           busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_PINS-1:0]   pinPeriph,
  output logic [NUM_GROUPS-1:0] irqOut
);

  ctrl_strobe_t strb;

  gpio_irq_decode #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_dec (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .rdata     (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinPeriph (pinPeriph),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busValid,
  input logic                  busWrite,
  input logic [11:0]           busAddr,
  input logic [31:0]           busWdata,
  input logic [31:0]           busRdata,
  input logic [NUM_PINS-1:0]   pinOe,
  input logic [NUM_PINS-1:0]   pinPeriph,
  input logic [NUM_GROUPS-1:0] irqOut
);

  localparam logic [12:0] CFG_LIMIT = 13'(4 * NUM_PINS);

  logic gapAddr;
  assign gapAddr = ({1'b0, busAddr} >= CFG_LIMIT) && !busAddr[11];

  // R1: first cycle out of reset is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == '0) && (pinOe == '0) && (pinPeriph == '0));

  // R3: a pin is never driven while handed to the peripheral
  p_oe_excl_periph_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & pinPeriph) == '0);

  // R3: writing output mode with bit 5 clear to pin 0 enables its driver
  p_out_mode_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 12'h000 && busWdata[3:1] == 3'd1
     && !busWdata[5]) |=> pinOe[0]);

  // R3: writing bit 5 to pin 0 selects the peripheral and drops the driver
  p_periph_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 12'h000 && busWdata[5])
    |=> (pinPeriph[0] && !pinOe[0]));

  // R9: a group line, once up, only drops after a write
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> ((irqOut & $past(irqOut)) == $past(irqOut)));

  // R10: reads in the gap between the regions return zero
  p_gap_reads_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && gapAddr) |=> (busRdata == 32'h0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .pinOe     (pinOe),
  .pinPeriph (pinPeriph),
  .irqOut    (irqOut)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

  localparam int NP = 64;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOe;
  logic [NP-1:0] pinPeriph;
  logic [NG-1:0] irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pinPeriph(pinPeriph),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk);
    pinIn[p] = v;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); check("R1 pin0 word", 64'(d), 64'h0E);
    pinIn[63] = 1'b1;
    rd(12'h0FC, d); check("R1 pin63 word with input high", 64'(d), 64'h0F);
    pinIn[63] = 1'b0;
    check("R1 oe", 64'(pinOe), 64'h0);
    check("R1 periph", 64'(pinPeriph), 64'h0);
    check("R1 irq", 64'(irqOut), 64'h0);
    rd(12'h800, d); check("R1 pending g0", 64'(d), 64'h0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] d;
    pinIn[3] = 1'b1;
    wr(12'h00C, 32'h0005_1213);
    rd(12'h00C, d); check("R2 stored fields", 64'(d), 64'h0005_0203);
    check("R2 pinOut", 64'(pinOut[3]), 64'h1);
    check("R3 oe in output mode", 64'(pinOe[3]), 64'h1);
    wr(12'h00C, 32'h0005_0222);
    check("R2 pinOut low", 64'(pinOut[3]), 64'h0);
    check("R3 oe off when periph", 64'(pinOe[3]), 64'h0);
    check("R3 periph select", 64'(pinPeriph[3]), 64'h1);
    pinIn[3] = 1'b0;
    rd(12'h00C, d); check("R2 bit0 is input level", 64'(d), 64'h0005_0222);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(12'h028, 32'h0002_0208);
    setPin(10, 1'b1); @(negedge clk);
    check("R4 rising sets irq g2", 64'(irqOut[2]), 64'h1);
    rd(12'h880, d); check("R7 g2 word0 bit10", 64'(d), 64'h400);
    wr(12'h880, 32'h400);
    check("R4 steady high no re-set", 64'(irqOut[2]), 64'h0);
    setPin(10, 1'b0); @(negedge clk);
    check("R4 falling ignored in rising mode", 64'(irqOut), 64'h0);
    wr(12'h028, 32'h0002_020A);
    setPin(10, 1'b1); @(negedge clk);
    check("R4 rising ignored in falling mode", 64'(irqOut), 64'h0);
    setPin(10, 1'b0); @(negedge clk);
    check("R4 falling sets", 64'(irqOut[2]), 64'h1);
    wr(12'h880, 32'h400);
    wr(12'h0A0, 32'h0007_020C);
    setPin(40, 1'b1); @(negedge clk);
    rd(12'h9C4, d); check("R4 both-edge rise, R7 g7 word1", 64'(d), 64'h100);
    wr(12'h9C4, 32'h100);
    setPin(40, 1'b0); @(negedge clk);
    check("R4 both-edge fall", 64'(irqOut[7]), 64'h1);
    wr(12'h9C4, 32'h100);
    check("R8 cleared g7", 64'(irqOut), 64'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(12'h050, 32'h0001_0204);
    setPin(20, 1'b1); @(negedge clk);
    check("R5 level high sets", 64'(irqOut[1]), 64'h1);
    wr(12'h840, 32'h0010_0000);
    rd(12'h840, d); check("R5 re-set while high", 64'(d), 64'h0010_0000);
    setPin(20, 1'b0);
    wr(12'h840, 32'h0010_0000);
    rd(12'h840, d); check("R5 clear sticks when low", 64'(d), 64'h0);
    wr(12'h050, 32'h0001_0206);
    @(negedge clk);
    check("R5 level low sets", 64'(irqOut[1]), 64'h1);
    setPin(20, 1'b1);
    wr(12'h840, 32'h0010_0000);
    check("R5 level low cleared once high", 64'(irqOut[1]), 64'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(12'h0CC, 32'h0000_0000);
    wr(12'h0D0, 32'h0000_0203);
    wr(12'h0D4, 32'h0000_0228);
    @(negedge clk);
    pinIn[50] = 1'b1; pinIn[51] = 1'b1; pinIn[52] = 1'b1; pinIn[53] = 1'b1;
    @(negedge clk);
    pinIn[50] = 1'b0; pinIn[51] = 1'b0; pinIn[52] = 1'b0; pinIn[53] = 1'b0;
    @(negedge clk);
    check("R6 no irq from quiet/output/periph", 64'(irqOut), 64'h0);
    rd(12'h804, d); check("R6 no pending g0 word1", 64'(d), 64'h0);
  endtask

  task automatic t_groups();
    logic [31:0] d;
    wr(12'h004, 32'h0003_0208);
    wr(12'h008, 32'h0003_0208);
    wr(12'h084, 32'h0004_0208);
    @(negedge clk);
    pinIn[1] = 1'b1; pinIn[2] = 1'b1; pinIn[33] = 1'b1;
    @(negedge clk);
    rd(12'h8C0, d); check("R7 g3 word0", 64'(d), 64'h6);
    rd(12'h904, d); check("R7 g4 word1", 64'(d), 64'h2);
    rd(12'h8C4, d); check("R7 g3 word1 empty", 64'(d), 64'h0);
    rd(12'h900, d); check("R7 g4 word0 empty", 64'(d), 64'h0);
    wr(12'h8C0, 32'h0);
    rd(12'h8C0, d); check("R8 zero write keeps", 64'(d), 64'h6);
    wr(12'h900, 32'h2);
    rd(12'h8C0, d); check("R8 other group untouched", 64'(d), 64'h6);
    wr(12'h8C0, 32'h2);
    rd(12'h8C0, d); check("R8 single bit cleared", 64'(d), 64'h4);
    check("R9 g3 still up", 64'(irqOut[3]), 64'h1);
    check("R9 g4 up", 64'(irqOut[4]), 64'h1);
    wr(12'h8C0, 32'h4);
    check("R9 g3 down", 64'(irqOut[3]), 64'h0);
    wr(12'h904, 32'h2);
    check("R9 all down", 64'(irqOut), 64'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); check("R10 gap reads zero", 64'(d), 64'h0);
    rd(12'h808, d); check("R10 missing word reads zero", 64'(d), 64'h0);
    wr(12'h808, 32'hFFFF_FFFF);
    rd(12'h000, d); check("R10 pin0 unchanged", 64'(d), 64'h0E);
    check("R10 irq unchanged", 64'(irqOut), 64'h0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_cfg_rw();
    t_edge();
    t_level();
    t_disabled();
    t_groups();
    t_unmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule